// File: doc/BRIEF.md
# I2C Bus Recovery Pulser

This block frees an I2C bus that a slave has left stuck, typically with SDA held low in the middle of a byte after an interrupted transfer. A start strobe makes it take the SCL and SDA pins away from the I2C master controller and release both lines, so that neither is driven. It then looks at the sampled lines. The bus is quiet when SCL and SDA both read high, and in that case the sequence ends with no clock pulse at all.

If the bus is not quiet, the block clocks SCL as an open-drain line. Each pulse pulls SCL low for one half period and then lets it float for one half period. The bus is tested again before every pulse. When the bus turns quiet, or when the pulse limit is used up, the pins go back to the controller. The block then raises a one-cycle done pulse together with a fail flag and the number of pulses it issued. Generating a STOP condition on the bus is left to the controller.

Software sets the half period as a count of clock cycles. It normally derives this value from a microsecond half period of (1,000,000 + f) / (2f), with integer division, where f is the bus rate in Hz.

Top module: `i2c_unstick`

## Requirements
- R1: After reset the pins belong to the controller (`pinOwn`=0), SCL is not driven, `done` and `fail` are 0 and `pulseCount` is 0.
- R2: A start strobe taken while idle sets `pinOwn` to 1 from the next cycle, with SCL released, `pulseCount` cleared to 0 and `fail` cleared to 0.
- R3: If SCL and SDA both read high at the first check, the sequence ends with no pulse: `done` is raised, `fail`=0 and `pulseCount`=0.
- R4: The bus is tested before every pulse, and the sequence ends at the first test that finds both lines high. `pulseCount` equals the number of low pulses driven on SCL.
- R5: Each pulse holds `sclDriveLow` high for exactly `halfPeriod` cycles, then low for `halfPeriod` cycles before the next test. A `halfPeriod` of 0 behaves as 1.
- R6: No more than MAX_PULSES pulses are issued (default 200). If the bus is still not quiet at the test after the last allowed pulse, the sequence ends with `fail`=1 and `pulseCount`=MAX_PULSES.
- R7: In the cycle `done` is high, and after it, `pinOwn` is 0 and SCL is not driven, whatever the outcome.
- R8: `done` is high for exactly one cycle per sequence. `fail` keeps its value until the next accepted start strobe.
- R9: A start strobe that arrives while the sequence runs, or in the `done` cycle, is ignored. It neither restarts the sequence nor clears `pulseCount`.
- R10: If the bus turns quiet at the same test at which the pulse limit is reached, the outcome is success (`fail`=0, `pulseCount`=MAX_PULSES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | One-cycle request to start a recovery sequence |
| sclIn | input | 1 | Sampled level of the SCL line |
| sdaIn | input | 1 | Sampled level of the SDA line |
| halfPeriod | input | HP_W (16) | Half period of the recovery clock, in clock cycles |
| sclDriveLow | output | 1 | When high, the SCL pad is pulled low (open drain) |
| pinOwn | output | 1 | 1: this block owns the pins; 0: the I2C controller owns them |
| done | output | 1 | One-cycle pulse when a sequence ends |
| fail | output | 1 | Set when the bus was still stuck after the last allowed pulse |
| pulseCount | output | CNT_W (8) | Number of pulses issued in the latest sequence |

## Verification
Two events can meet in one test cycle: the bus turning quiet and the pulse counter reaching its limit. The bench sets this up with a slave model that lets go of SDA after exactly MAX_PULSES clock pulses. It expects success with a full count, and it also runs the neighbouring cases of one pulse fewer and one pulse more. The bench also places a start strobe in the middle of a run and in the `done` cycle, and checks that the count and the pin ownership show no trace of either.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadTimer;   // reload the half-period timer
    logic clrCount;    // clear the pulse counter
    logic incCount;    // one more pulse issued
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOW,
    ST_HIGH,
    ST_FINISH
  } seqState_t;

endpackage

// File: rtl/i2c_unstick_dp.sv
module i2c_unstick_dp
  import i2c_unstick_pkg::*;
#(
  parameter int HP_W       = 16,
  parameter int MAX_PULSES = 200,
  parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [HP_W-1:0]  halfPeriod,
  output logic             timerDone,
  output logic             atLimit,
  output logic [CNT_W-1:0] pulseCount
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PULSES);

  logic [HP_W-1:0] timer;
  logic [HP_W-1:0] loadVal;

  // a zero half period is stretched to one cycle
  assign loadVal = (halfPeriod == '0) ? HP_W'(1) : halfPeriod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= HP_W'(1);
    end else if (strb.loadTimer) begin
      timer <= loadVal;
    end else if (timer > HP_W'(1)) begin
      timer <= timer - HP_W'(1);
    end
  end

  assign timerDone = (timer <= HP_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCount <= '0;
    end else if (strb.clrCount) begin
      pulseCount <= '0;
    end else if (strb.incCount) begin
      pulseCount <= pulseCount + CNT_W'(1);
    end
  end

  assign atLimit = (pulseCount == LIMIT);

endmodule

// File: rtl/i2c_unstick_ctrl.sv
module i2c_unstick_ctrl
  import i2c_unstick_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       timerDone,
  input  logic       atLimit,
  output seqStrobe_t strb,
  output logic       sclDriveLow,
  output logic       pinOwn,
  output logic       done,
  output logic       fail
);

  seqState_t state, stateNext;
  logic      busQuiet;
  logic      failSet;
  logic      accept;

  assign busQuiet = sclIn & sdaIn;
  assign accept   = (state == ST_IDLE) & startStb;

  always_comb begin
    stateNext = state;
    strb      = '0;
    failSet   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startStb) begin
          stateNext     = ST_CHECK;
          strb.clrCount = 1'b1;
        end
      end
      ST_CHECK: begin
        // quiet wins over the limit when both hold
        if (busQuiet) begin
          stateNext = ST_FINISH;
        end else if (atLimit) begin
          stateNext = ST_FINISH;
          failSet   = 1'b1;
        end else begin
          stateNext      = ST_LOW;
          strb.loadTimer = 1'b1;
          strb.incCount  = 1'b1;
        end
      end
      ST_LOW: begin
        if (timerDone) begin
          stateNext      = ST_HIGH;
          strb.loadTimer = 1'b1;
        end
      end
      ST_HIGH: begin
        if (timerDone) stateNext = ST_CHECK;
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      fail  <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept)       fail <= 1'b0;
      else if (failSet) fail <= 1'b1;
    end
  end

  assign sclDriveLow = (state == ST_LOW);
  assign pinOwn      = (state == ST_CHECK) | (state == ST_LOW) | (state == ST_HIGH);
  assign done        = (state == ST_FINISH);

endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
  import i2c_unstick_pkg::*;
#(
  parameter int HP_W       = 16,
  parameter int MAX_PULSES = 200,
  localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [HP_W-1:0]  halfPeriod,
  output logic             sclDriveLow,
  output logic             pinOwn,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] pulseCount
);

  seqStrobe_t strb;
  logic       timerDone;
  logic       atLimit;

  i2c_unstick_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStb   (startStb),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .timerDone  (timerDone),
    .atLimit    (atLimit),
    .strb       (strb),
    .sclDriveLow(sclDriveLow),
    .pinOwn     (pinOwn),
    .done       (done),
    .fail       (fail)
  );

  i2c_unstick_dp #(
    .HP_W      (HP_W),
    .MAX_PULSES(MAX_PULSES),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .halfPeriod(halfPeriod),
    .timerDone (timerDone),
    .atLimit   (atLimit),
    .pulseCount(pulseCount)
  );

endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
  parameter int MAX_PULSES = 200,
  parameter int CNT_W      = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic             sclDriveLow,
  input logic             pinOwn,
  input logic             done,
  input logic             fail,
  input logic [CNT_W-1:0] pulseCount
);

  // R2: an accepted start takes the pins and clears the result
  a_r2_start_takes_pins: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !pinOwn && !done) |=> (pinOwn && !sclDriveLow && pulseCount == '0 && !fail));

  // R6: the pulse count never passes the limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCount <= CNT_W'(MAX_PULSES));

  // R7: driving SCL only while the pins are owned
  a_r7_drive_needs_own: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> pinOwn);

  // R7: done coincides with pins handed back
  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!pinOwn && !sclDriveLow));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: fail only rises with done
  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> done);

  // R9: start while running leaves the count growing
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && pinOwn) |=> (pulseCount >= $past(pulseCount)));

  // R9: start in the done cycle does not reopen the sequence
  a_r9_done_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && done) |=> !pinOwn);

endmodule

bind i2c_unstick i2c_unstick_chk #(
  .MAX_PULSES(MAX_PULSES),
  .CNT_W     ($clog2(MAX_PULSES + 1))
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startStb   (startStb),
  .sclDriveLow(sclDriveLow),
  .pinOwn     (pinOwn),
  .done       (done),
  .fail       (fail),
  .pulseCount (pulseCount)
);

// File: tb/i2c_unstick_bench.sv
`timescale 1ns/1ps
module i2c_unstick_bench;

  localparam int HP_W  = 16;
  localparam int MAXP  = 200;
  localparam int CNT_W = $clog2(MAXP + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startStb = 1'b0;
  logic [HP_W-1:0]  halfPeriod = 16'd1;
  logic             sclDriveLow, pinOwn, done, fail;
  logic [CNT_W-1:0] pulseCount;

  // slave model
  int   holdPulses = 0;
  logic sclStuck = 1'b0;
  int   relCount = 0;
  logic prevDrive = 1'b0;
  int   lowRun = 0;
  int   badLow = 0;
  int   expLow = 1;
  logic sclIn, sdaIn;

  assign sclIn = !sclDriveLow && !sclStuck;
  assign sdaIn = (relCount >= holdPulses);

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  i2c_unstick #(.HP_W(HP_W), .MAX_PULSES(MAX_PULSES_C)) u_i2c_unstick (
    .clk(clk), .rstN(rstN), .startStb(startStb), .sclIn(sclIn), .sdaIn(sdaIn),
    .halfPeriod(halfPeriod), .sclDriveLow(sclDriveLow), .pinOwn(pinOwn),
    .done(done), .fail(fail), .pulseCount(pulseCount)
  );
  localparam int MAX_PULSES_C = MAXP;

  // count released pulses and measure low widths (R5)
  always @(negedge clk) begin
    cycles <= cycles + 1;
    prevDrive <= sclDriveLow;
    if (sclDriveLow) lowRun <= lowRun + 1;
    if (prevDrive && !sclDriveLow) begin
      relCount <= relCount + 1;
      if (lowRun != expLow) badLow <= badLow + 1;
      lowRun <= 0;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expCount(input int n, input logic stuck);
    if (stuck) return MAXP;
    return (n <= MAXP) ? n : MAXP;
  endfunction

  function automatic logic expFail(input int n, input logic stuck);
    return stuck || (n > MAXP);
  endfunction

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one recovery sequence; midStart/doneStart inject ignored strobes (R9)
  task automatic runSeq(input int n, input logic stuck, input int hp,
                        input logic midStart, input logic doneStart);
    int waited;
    @(negedge clk);
    holdPulses = n;
    sclStuck   = stuck;
    halfPeriod = HP_W'(hp);
    expLow     = (hp == 0) ? 1 : hp;
    relCount   = 0;
    badLow     = 0;
    startStb   = 1'b1;
    @(negedge clk);
    startStb   = 1'b0;
    // R2
    chk(pinOwn && !sclDriveLow && pulseCount == 0 && !fail, "R2 start",
        {pinOwn, sclDriveLow, fail}, 3'b100);
    waited = 0;
    while (!done) begin
      if (midStart && waited == 7) startStb = 1'b1;
      else startStb = 1'b0;
      @(negedge clk);
      waited++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", waited);
        finishRun();
      end
    end
    startStb = 1'b0;
    // R3/R4/R6/R10 outcome, R7 release
    chk(pulseCount == CNT_W'(expCount(n, stuck)), "R4 R6 R10 count",
        pulseCount, expCount(n, stuck));
    chk(fail == expFail(n, stuck), "R6 R10 fail", fail, expFail(n, stuck));
    chk(!pinOwn && !sclDriveLow, "R7 release", pinOwn, 0);
    chk(badLow == 0, "R5 low width", badLow, 0);
    if (doneStart) startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    chk(!done, "R8 done single", done, 0);
    chk(!pinOwn, "R9 ignored start", pinOwn, 0);
    repeat (3) @(negedge clk);
    chk(fail == expFail(n, stuck), "R8 fail held", fail, expFail(n, stuck));
    chk(pulseCount == CNT_W'(expCount(n, stuck)), "R9 count kept",
        pulseCount, expCount(n, stuck));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    chk(!pinOwn && !sclDriveLow && !done && !fail && pulseCount == 0,
        "R1 reset", {pinOwn, sclDriveLow, done, fail}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!pinOwn && !done, "R1 idle", pinOwn, 0);

    runSeq(0,   1'b0, 2, 1'b0, 1'b0);   // R3 quiet bus
    runSeq(1,   1'b0, 0, 1'b0, 1'b0);   // R5 zero half period
    runSeq(9,   1'b0, 3, 1'b1, 1'b1);   // R9 ignored strobes
    runSeq(MAXP - 1, 1'b0, 1, 1'b0, 1'b0);
    runSeq(MAXP,     1'b0, 1, 1'b0, 1'b0); // R10 quiet at limit
    runSeq(MAXP + 1, 1'b0, 1, 1'b0, 1'b1); // R6 limit reached
    runSeq(0,   1'b1, 2, 1'b0, 1'b0);   // R6 SCL stuck low
    runSeq(4,   1'b0, 2, 1'b0, 1'b0);   // R2 fail cleared after failure
    for (int i = 0; i < 10; i++) begin
      runSeq(int'($urandom_range(0, MAXP + 10)), 1'b0,
             int'($urandom_range(1, 4)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)));
    end
    finishRun();
  end

endmodule